// File: doc/BRIEF.md
# Two-Wire Bus DAC Code Slave

This block is a write-only slave on a two-wire serial bus. It holds an 8-bit converter code and a power-down flag, and the bus master programs both. Each bus line first passes through a two-flop synchronizer and a three-sample majority filter. The block then tracks START, repeated START and STOP conditions and shifts in an address byte followed by one code byte. It acknowledges each byte by enabling an open-drain pull-down on the data line.

The lowest bit of the address byte is not a read/write bit. It is a power-down request. New values take effect only on a STOP that follows a fully acknowledged second byte. When power-down is requested, the master clocks the second byte out of the slave. The slave leaves the line released during that byte, so the master reads ones.

Top module: `dac_bus_slave`

## Requirements
- R1: After reset, `dac_code` is 0, `shutdown` is 0 and `sda_pull` is 0.
- R2: The 7-bit address is taken MSB first after a START. The block answers to 0x30 + `strap` (8-bit form 0x60, 0x62, 0x64, 0x66). For a matching address it holds `sda_pull` high through the whole 9th clock, so the line reads 0 while SCL is high.
- R3: For a non-matching address, including the all-zero general call, the block does not acknowledge. It then ignores the bus until the next START.
- R4: Bit 0 of the address byte is the power-down request: 1 asks for shutdown and 0 asks for normal operation. The block acknowledges either value.
- R5: A STOP or repeated START that comes directly after the address byte leaves `dac_code` and `shutdown` unchanged.
- R6: The second byte is the code, straight binary and MSB first, and it is acknowledged. `dac_code` and `shutdown` change together, and only on a STOP after that acknowledge. A repeated START in that position discards the update.
- R7: In power-down (read) mode the block keeps `sda_pull` low for all 8 data bits, so the line reads ones. The following STOP sets `shutdown` to 1 and leaves `dac_code` unchanged.
- R8: Bytes after the second byte get no acknowledge and are ignored. The pending update is still committed by the next STOP.
- R9: Each output responds 6 clock cycles after the raw line edge that causes it. A pulse of a single clock cycle on either line is filtered out and has no effect.
- R10: Changing `strap` moves the matching address. A transfer to the previous address is then not acknowledged and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap | input | 2 | Address select, added to 0x30 |
| sda_pull | output | 1 | Open-drain pull-down enable for the data line |
| dac_code | output | 8 | Committed converter code |
| shutdown | output | 1 | Committed power-down flag |

## Verification
Every output is due exactly 6 clock cycles after the raw line change that causes it. That delay covers two synchronizer flops, two filter samples, the filtered-value register and the state register. The bench keeps ideal output values and updates them at the moment it drives each bus edge. It delays them through a 6-stage line and compares them to the outputs on every falling clock edge. Each bus phase lasts 10 cycles, so the bench samples every acknowledge and every released data bit after the pull-down has settled. It checks the committed outputs only once the STOP has had time to take effect.

// File: rtl/dac_bus_slave.sv
module dac_bus_slave #(
  parameter logic [6:0] ADDR_BASE = 7'h30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] strap,
  output logic       sda_pull,
  output logic [7:0] dac_code,
  output logic       shutdown
);
  typedef enum logic [2:0] {IDLE, ADDR, ACK_A, DATA, ACK_D, DONE} st_t;

  function automatic logic maj(input logic [2:0] h);
    return (h[0] & h[1]) | (h[1] & h[2]) | (h[0] & h[2]);
  endfunction

  logic [1:0] sy1, sy2, flt, flt_d;
  logic [2:0] h_scl, h_sda;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '1; sy2 <= '1; h_scl <= '1; h_sda <= '1; flt <= '1; flt_d <= '1;
    end else begin
      sy1   <= {scl_in, sda_in};
      sy2   <= sy1;
      h_scl <= {h_scl[1:0], sy2[1]};
      h_sda <= {h_sda[1:0], sy2[0]};
      flt   <= {maj(h_scl), maj(h_sda)};
      flt_d <= flt;
    end

  wire scl_hi   = flt[1] & flt_d[1];
  wire start_ev = scl_hi & flt_d[0] & ~flt[0];
  wire stop_ev  = scl_hi & ~flt_d[0] & flt[0];
  wire scl_rise = flt[1] & ~flt_d[1];
  wire scl_fall = ~flt[1] & flt_d[1];
  wire [6:0] my_addr = {ADDR_BASE[6:2], ADDR_BASE[1:0] + strap};

  st_t        st;
  logic [7:0] shreg, pend_code;
  logic [3:0] bitcnt;
  logic       rd, pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; shreg <= '0; bitcnt <= '0; rd <= 1'b0; pend <= 1'b0;
      pend_code <= '0; sda_pull <= 1'b0; dac_code <= '0; shutdown <= 1'b0;
    end else if (start_ev) begin
      st <= ADDR; bitcnt <= '0; pend <= 1'b0; sda_pull <= 1'b0;
    end else if (stop_ev) begin
      st <= IDLE; pend <= 1'b0; sda_pull <= 1'b0;
      if (pend) begin
        shutdown <= rd;
        if (!rd) dac_code <= pend_code;
      end
    end else if (scl_rise && (st == ADDR || st == DATA) && bitcnt != 4'd8) begin
      shreg  <= {shreg[6:0], flt[0]};
      bitcnt <= bitcnt + 4'd1;
    end else if (scl_fall) begin
      case (st)
        ADDR: if (bitcnt == 4'd8) begin
          if (shreg[7:1] == my_addr && shreg[7:1] != 7'd0) begin
            st <= ACK_A; rd <= shreg[0]; sda_pull <= 1'b1;
          end else st <= IDLE;
        end
        ACK_A: begin st <= DATA; bitcnt <= '0; sda_pull <= 1'b0; end
        DATA: if (bitcnt == 4'd8) begin
          st <= ACK_D; pend_code <= shreg; sda_pull <= 1'b1;
        end
        ACK_D: begin st <= DONE; sda_pull <= 1'b0; pend <= 1'b1; end
        default: ;
      endcase
    end

  a_r6_code_only_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> $past(stop_ev));
  a_r4_flag_only_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shutdown) |-> $past(stop_ev));
  a_r7_code_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> !shutdown);
  a_r2_pull_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (st == ACK_A || st == ACK_D));
  a_r6_start_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !pend);
  a_r8_no_pull_extra: assert property (@(posedge clk) disable iff (!rst_n)
    st == DONE |-> !sda_pull);
endmodule

// File: tb/sim_dac_bus_slave.sv
module sim_dac_bus_slave;
  localparam int Q = 10;
  localparam int LAT = 6;
  logic clk = 0, rst_n = 0, m_scl = 1, m_sda = 1;
  logic [1:0] strap = 0;
  wire sda_pull, shutdown, sda_line;
  wire [7:0] dac_code;
  int errors = 0, checks = 0;
  bit done = 0, live = 0;
  logic [7:0] i_dac = 0; logic i_sd = 0, i_oe = 0;
  logic [7:0] dd [LAT]; logic ds [LAT]; logic doe [LAT];

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  dac_bus_slave u0 (.clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .strap(strap), .sda_pull(sda_pull), .dac_code(dac_code), .shutdown(shutdown));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  always @(posedge clk)
    if (!rst_n) for (int k = 0; k < LAT; k++) begin dd[k] <= 0; ds[k] <= 0; doe[k] <= 0; end
    else begin
      dd[0] <= i_dac; ds[0] <= i_sd; doe[0] <= i_oe;
      for (int k = 1; k < LAT; k++) begin dd[k] <= dd[k-1]; ds[k] <= ds[k-1]; doe[k] <= doe[k-1]; end
    end

  always @(negedge clk) if (live) begin
    chk(dac_code == dd[LAT-1], "R6/R9 dac_code cycle", dac_code, dd[LAT-1]);
    chk(shutdown == ds[LAT-1], "R4/R9 shutdown cycle", shutdown, ds[LAT-1]);
    chk(sda_pull == doe[LAT-1], "R2/R9 sda_pull cycle", sda_pull, doe[LAT-1]);
  end

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    m_sda = 1; m_scl = 1; w(Q); m_sda = 0; w(Q); m_scl = 0; w(Q);
  endtask
  task automatic bus_restart;
    m_sda = 1; w(Q); m_scl = 1; w(Q); m_sda = 0; w(Q); m_scl = 0; w(Q);
  endtask

  task automatic bit_out(input bit v, input bit set_oe, input bit chk_hi);
    m_sda = v; w(Q); m_scl = 1; w(Q);
    if (chk_hi) chk(sda_line == 1, "R7 released data bit", sda_line, 1);
    m_scl = 0; if (set_oe) i_oe = 1; w(Q);
  endtask

  task automatic byte_out(input [7:0] b, input bit ack, input bit rdchk, input string tag);
    for (int i = 7; i >= 0; i--) bit_out(rdchk ? 1'b1 : b[i], (i == 0) && ack, rdchk);
    m_sda = 1; w(Q); m_scl = 1; w(Q);
    chk(sda_line == !ack, tag, sda_line, !ack);
    m_scl = 0; i_oe = 0; w(Q);
  endtask

  // endk: 0 stop, 1 repeated start, 2 leave bus with SCL low
  task automatic txn(input bit do_start, input [6:0] a, input bit sd, input int nb,
                     input [7:0] d1, input [7:0] d2, input int endk);
    bit match = (a == 7'h30 + 7'(strap)) && (a != 0);
    if (do_start) bus_start;
    byte_out({a, sd}, match, 0, match ? "R2 address ack" : "R3 no ack on mismatch");
    if (nb >= 2) byte_out(d1, match, match && sd, "R6 code byte ack");
    if (nb >= 3) byte_out(d2, 0, 0, "R8 extra byte not acked");
    if (endk == 0) begin
      m_sda = 0; w(Q); m_scl = 1; w(Q); m_sda = 1;
      if (match && nb >= 2) begin i_sd = sd; if (!sd) i_dac = d1; end
      w(Q);
    end else if (endk == 1) bus_restart;
  endtask

  task automatic endchk(input string tag);
    chk(dac_code == i_dac, tag, dac_code, i_dac);
    chk(shutdown == i_sd, tag, shutdown, i_sd);
  endtask

  initial begin
    w(3);
    chk(dac_code == 0 && shutdown == 0 && sda_pull == 0, "R1 reset state",
        {dac_code, shutdown, sda_pull}, 0);
    rst_n = 1; w(2); live = 1; w(Q);
    txn(1, 7'h30, 0, 2, 8'hA5, 0, 0); endchk("R6 write commits at STOP");
    txn(1, 7'h30, 0, 2, 8'h5A, 0, 1); endchk("R6 restart cancels");
    txn(0, 7'h30, 0, 2, 8'h3C, 0, 0); endchk("R6 write after restart");
    txn(1, 7'h30, 0, 1, 0, 0, 0); endchk("R5 address-only STOP");
    txn(1, 7'h30, 1, 1, 0, 0, 0); endchk("R5 address-only shutdown request");
    txn(1, 7'h30, 1, 1, 0, 0, 1);
    txn(0, 7'h30, 0, 2, 8'h81, 0, 0); endchk("R5 restart after address");
    txn(1, 7'h31, 0, 2, 8'hEE, 0, 0); endchk("R3 mismatch ignored");
    txn(1, 7'h00, 0, 2, 8'hEE, 0, 0); endchk("R3 general call ignored");
    txn(1, 7'h30, 0, 3, 8'h77, 8'h11, 0); endchk("R8 pending survives extra byte");
    txn(1, 7'h30, 1, 2, 8'h00, 0, 0); endchk("R7 read mode sets shutdown");
    chk(shutdown == 1 && dac_code == 8'h77, "R7 code kept", {dac_code, shutdown}, {8'h77, 1'b1});
    txn(1, 7'h30, 0, 2, 8'h80, 0, 0); endchk("R4 normal mode restores");
    strap = 2; w(Q);
    txn(1, 7'h30, 0, 2, 8'h01, 0, 0); endchk("R10 old address ignored");
    txn(1, 7'h32, 0, 2, 8'hC3, 0, 0); endchk("R10 strap address works");
    txn(1, 7'h32, 0, 2, 8'h42, 0, 2);
    m_sda = 1; w(Q); m_scl = 1; w(Q); m_sda = 0; w(1); m_sda = 1; w(Q);
    m_scl = 0; w(Q);
    m_sda = 0; w(Q); m_scl = 1; w(Q); m_sda = 1; i_dac = 8'h42; i_sd = 0; w(Q);
    endchk("R9 one-cycle glitch filtered");
    strap = 0; w(Q);
    txn(1, 7'h30, 0, 2, 8'hFF, 0, 0); endchk("R6 full-scale code");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule